// File: doc/BRIEF.md
# Anode PWM Dimming Generator

This block produces the brightness pulse that gates every anode (segment) output of a multiplexed vacuum fluorescent display during one grid slot. A 10-bit brightness code is captured from the dimming latch at the start of each slot, clamped just below full scale, and compared against a counter that advances once per bit time. A bit time is four enabled oscillator clocks. The segment gate is high from the start of the slot until the count reaches the captured code.

In a chain of drivers, one device runs as the master and the others run as slaves. The master generates the pulse itself and copies it onto a dedicated output. Each slave ignores its own generator and gates its segments directly from the pulse it receives from the master. Loading of the code, sequencing of the grids and the high-voltage drivers are handled outside this block.

Top module: `anode_dimmer`

## Requirements
- R1: In master mode, with code C (below 1016) captured at a slot start, `seg_gate` is high for the first C bit times of the slot and low for the remaining bit times, which gives a duty of C/1024.
- R2: Any captured code from 1016 to 1023 behaves exactly like code 1016, so the pulse is high for 1016 of the 1024 bit times.
- R3: A captured code of 0 keeps `seg_gate` low for the whole slot in master mode.
- R4: One bit time is four clock cycles in which `osc_en` is high. Cycles with `osc_en` low do not advance the bit count.
- R5: While `rst_n` is low and after it is released, the captured level is 0, and `seg_gate` and `pulse_out` are low in master mode until the first slot start with a nonzero code.
- R6: Changing `level_code` has no effect on the pulse until the next cycle in which `slot_start` is high. The code is captured on that cycle.
- R7: In slave mode (`master_sel` = 0), `seg_gate` equals `pulse_in` in the same cycle, whatever the internal count and code are.
- R8: `pulse_out` equals the internal pulse in master mode and is held low in slave mode.
- R9: In master mode, `pulse_in` has no effect on `seg_gate` or `pulse_out`.
- R10: `slot_start` restarts both the bit-time prescaler and the bit counter, even in the middle of a slot. With no further strobe, the counter wraps back to 0 after 1024 bit times and the pulse repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Oscillator clock enable, one per display oscillator period |
| slot_start | input | 1 | Grid-slot start strobe from the timing generator |
| level_code | input | 10 | Brightness code from the dimming latch |
| master_sel | input | 1 | 1 = master (internal PWM), 0 = slave (follow `pulse_in`) |
| pulse_in | input | 1 | Dimming pulse received from a master device |
| seg_gate | output | 1 | Enable that gates all segment outputs |
| pulse_out | output | 1 | Dimming pulse forwarded to slave devices |

## Verification
The hardest situation to reach from the ports is a change of `level_code` in the middle of a slot while the counter sits between the old and new codes, together with a restart strobe that arrives partway through a bit time. The stimulus sets a small code at a slot start and raises it to a large one about twenty bit times later. It then fires `slot_start` in the middle of a slot while `osc_en` is gapped, so the prescaler is caught at a nonzero phase. A cycle-by-cycle reference model checks that the pulse keeps its old length and that the prescaler restarts cleanly.

// File: rtl/anode_dim_pkg.sv
// Package: anode_dim_pkg
// Shared constants and helpers for the anode dimming generator.
// Assumes the brightness code is an unsigned binary value.
package anode_dim_pkg;
    typedef enum logic {
        SRC_EXTERNAL = 1'b0,
        SRC_INTERNAL = 1'b1
    } pulse_src_e;

    localparam int unsigned DEF_CODE_W   = 10;
    localparam int unsigned DEF_PRESCALE = 4;
    localparam int unsigned DEF_DUTY_MAX = 1016;
endpackage

// File: rtl/dim_bit_tick.sv
// Module: dim_bit_tick
// Divides the oscillator enable by PRESCALE and emits one bit-time tick
// per PRESCALE enabled cycles. A restart returns the phase to zero.
// Assumes PRESCALE >= 1. Restart has priority over counting.
module dim_bit_tick #(
    parameter int unsigned PRESCALE = anode_dim_pkg::DEF_PRESCALE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic osc_en,
    output logic bit_tick
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase_q;

    // Tick on the last enabled phase of the bit time
    assign bit_tick = osc_en && !restart && (phase_q == LAST);

    // Phase counter that wraps every PRESCALE enabled cycles
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (osc_en) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_spacing
            // Two ticks never come back to back when a bit time spans several cycles
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                bit_tick |=> !bit_tick);
        end
    endgenerate
endmodule

// File: rtl/dim_slot_counter.sv
// Module: dim_slot_counter
// Counts bit times within a grid slot. It is cleared by the slot strobe
// and wraps naturally at 2**CODE_W bit times.
module dim_slot_counter #(
    parameter int unsigned CODE_W = anode_dim_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              bit_tick,
    output logic [CODE_W-1:0] slot_count
);
    // Bit-time counter with restart priority
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            slot_count <= '0;
        end else if (bit_tick) begin
            slot_count <= slot_count + 1'b1;
        end
    end

    // A tick advances the count by exactly one, modulo the slot length
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !restart) |=> (slot_count == $past(slot_count) + 1'b1));
endmodule

// File: rtl/dim_level_hold.sv
// Module: dim_level_hold
// Captures the brightness code at each slot start and clamps it to DUTY_MAX.
// Assumes DUTY_MAX < 2**CODE_W. Between strobes the held level is frozen.
module dim_level_hold #(
    parameter int unsigned CODE_W   = anode_dim_pkg::DEF_CODE_W,
    parameter int unsigned DUTY_MAX = anode_dim_pkg::DEF_DUTY_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] level
);
    localparam logic [CODE_W-1:0] CEIL = CODE_W'(DUTY_MAX);

    logic [CODE_W-1:0] clamped;

    // Saturate codes at or above the ceiling
    assign clamped = (code_in >= CEIL) ? CEIL : code_in;

    // Hold register that is loaded only at a slot boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (capture) begin
            level <= clamped;
        end
    end

    // The held level never exceeds the ceiling
    p_level_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CEIL);
    // Outside a strobe the held level does not move
    p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(level));
endmodule

// File: rtl/anode_dimmer.sv
// Module: anode_dimmer (top)
// Generates the segment gate pulse for each grid slot from a clamped
// brightness code and selects internal or external pulse by mode.
// Assumes slot_start is a one-cycle strobe and osc_en is a clock enable.
module anode_dimmer #(
    parameter int unsigned CODE_W   = anode_dim_pkg::DEF_CODE_W,
    parameter int unsigned PRESCALE = anode_dim_pkg::DEF_PRESCALE,
    parameter int unsigned DUTY_MAX = anode_dim_pkg::DEF_DUTY_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic              slot_start,
    input  logic [CODE_W-1:0] level_code,
    input  logic              master_sel,
    input  logic              pulse_in,
    output logic              seg_gate,
    output logic              pulse_out
);
    import anode_dim_pkg::*;

    logic              bit_tick;
    logic [CODE_W-1:0] slot_count;
    logic [CODE_W-1:0] level;
    logic              pwm_on;
    pulse_src_e        src;

    dim_bit_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (slot_start),
        .osc_en   (osc_en),
        .bit_tick (bit_tick)
    );

    dim_slot_counter #(.CODE_W(CODE_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (slot_start),
        .bit_tick   (bit_tick),
        .slot_count (slot_count)
    );

    dim_level_hold #(.CODE_W(CODE_W), .DUTY_MAX(DUTY_MAX)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (slot_start),
        .code_in (level_code),
        .level   (level)
    );

    // Internal pulse is high while the slot count is below the held level
    assign pwm_on = (slot_count < level);

    // Source selection between internal PWM and the received pulse
    assign src = master_sel ? SRC_INTERNAL : SRC_EXTERNAL;

    // Drive the segment gate and the forwarded pulse by mode
    always_comb begin
        if (src == SRC_INTERNAL) begin
            seg_gate  = pwm_on;
            pulse_out = pwm_on;
        end else begin
            seg_gate  = pulse_in;
            pulse_out = 1'b0;
        end
    end

    // A strobe leaves the counter at zero on the next cycle
    p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> (slot_count == '0));
    // A zero level keeps the master gate dark
    p_dark_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && level == '0) |-> !seg_gate);
    // Slaves never forward a pulse
    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> !pulse_out);
    // The master gate and the forwarded pulse agree
    p_master_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |-> (pulse_out == seg_gate));
endmodule

// File: tb/anode_dimmer_test.sv
// Bench: behavioural reference model compared against the design on every clock.
module anode_dimmer_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       slot_start = 1'b0;
    logic [9:0] level_code = '0;
    logic       master_sel = 1'b1;
    logic       pulse_in = 1'b0;
    logic       seg_gate, pulse_out;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R5";

    // Reference model state
    int m_pre = 0, m_cnt = 0, m_lvl = 0;
    logic [15:0] lfsr = 16'hACE1;
    int osc_mode = 0;      // 0: always enabled, 1: every other cycle
    int cyc = 0;
    logic pulse_rand = 1'b0;
    int high_tally = 0;

    always #(CLK_P/2) clk = ~clk;

    anode_dimmer uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .slot_start(slot_start),
        .level_code(level_code), .master_sel(master_sel), .pulse_in(pulse_in),
        .seg_gate(seg_gate), .pulse_out(pulse_out)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, then compare a quarter period later
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_lvl = 0;
        end else if (slot_start) begin
            m_pre = 0; m_cnt = 0;
            m_lvl = (level_code >= 10'd1016) ? 1016 : int'(level_code);
        end else if (osc_en) begin
            if (m_pre == 3) begin
                m_pre = 0;
                m_cnt = (m_cnt + 1) % 1024;
            end else begin
                m_pre++;
            end
        end
        #(CLK_P/4);
        begin
            logic pwm;
            pwm = (m_cnt < m_lvl);
            check(cur_req, seg_gate, master_sel ? pwm : pulse_in, "seg_gate");
            check(cur_req, pulse_out, master_sel ? pwm : 1'b0, "pulse_out");
            if (seg_gate) high_tally++;
        end
        // drive next inputs well away from the edge
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pulse_in = lfsr[0];
        osc_en = (osc_mode == 0) ? 1'b1 : cyc[0];
        slot_start = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic new_slot(input logic [9:0] code);
        level_code = code;
        slot_start = 1'b1;
        step();
        high_tally = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_P/4);
        // R5: reset state, even with a code present and the prescaler enabled
        cur_req = "R5";
        level_code = 10'd500;
        osc_en = 1'b1;
        run(4);
        check("R5", seg_gate, 1'b0, "seg_gate in reset");
        rst_n = 1'b1;
        run(20);
        check("R5", pulse_out, 1'b0, "pulse_out after reset");

        // R1: nominal code, one full slot, tally of high cycles (100 bit times * 4)
        cur_req = "R1";
        new_slot(10'd100);
        high_tally = (seg_gate === 1'b1) ? 1 : 0;
        run(1023 * 4 + 3);
        check("R1", high_tally == 400, 1'b1, "high cycles for code 100 == 400");

        // R10: without a strobe the count wraps and the pulse repeats
        cur_req = "R10";
        run(20);
        check("R10", seg_gate, 1'b1, "pulse repeats after wrap");

        // R2: top code clamps to 1016 bit times
        cur_req = "R2";
        new_slot(10'd1023);
        high_tally = (seg_gate === 1'b1) ? 1 : 0;
        run(1023 * 4 + 3);
        check("R2", high_tally == 1016 * 4, 1'b1, "high cycles for code 1023 == 4064");
        new_slot(10'd1016);
        run(1016 * 4 + 2);
        check("R2", seg_gate, 1'b0, "code 1016 ends at bit 1016");

        // R3: zero code stays dark
        cur_req = "R3";
        new_slot(10'd0);
        high_tally = (seg_gate === 1'b1) ? 1 : 0;
        run(600);
        check("R3", high_tally == 0, 1'b1, "no high cycle for code 0");

        // R6: code change mid slot takes effect only at the next strobe
        cur_req = "R6";
        new_slot(10'd30);
        run(20 * 4);
        level_code = 10'd900;
        run(40 * 4);
        check("R6", seg_gate, 1'b0, "pulse kept old length after mid-slot change");
        new_slot(10'd900);
        run(200 * 4);
        check("R6", seg_gate, 1'b1, "new code used after strobe");

        // R4: gapped oscillator enable stretches the bit time; R10 restart mid bit time
        cur_req = "R4";
        osc_mode = 1;
        new_slot(10'd5);
        run(5 * 8 - 2);
        check("R4", seg_gate, 1'b1, "still high before 5 gapped bit times");
        run(4);
        check("R4", seg_gate, 1'b0, "low after 5 gapped bit times");
        cur_req = "R10";
        new_slot(10'd3);
        run(5);
        new_slot(10'd3);
        run(3 * 8 + 4);
        osc_mode = 0;
        run(200);

        // R9: master ignores pulse_in (random pulse_in every cycle above and here)
        cur_req = "R9";
        new_slot(10'd50);
        run(400);

        // R7 and R8: slave follows pulse_in, forwards nothing
        cur_req = "R7";
        master_sel = 1'b0;
        new_slot(10'd700);
        run(500);
        cur_req = "R8";
        pulse_in = 1'b1;
        #(CLK_P/8);
        check("R8", pulse_out, 1'b0, "slave pulse_out low");
        check("R7", seg_gate, 1'b1, "slave seg_gate follows pulse_in high");
        pulse_in = 1'b0;
        #(CLK_P/8);
        check("R7", seg_gate, 1'b0, "slave seg_gate follows pulse_in low");
        run(100);
        master_sel = 1'b1;
        cur_req = "R8";
        run(200);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule